// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Load-Use Stall Unit

This block is the combinational data-hazard logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each stage register carries register addresses, a write-enable, a load flag and a nop (invalid) bit. From these fields alone, the unit picks where each execute-stage operand comes from. An operand can come from the register file read, from the result held after execute, or from the value about to be written back. The store-data operand of a store in execute uses the same selection.

Sometimes a dependency cannot be covered by forwarding. This happens when the instruction in decode needs a value that the load now in execute has not yet fetched. In that case the unit raises a one-cycle freeze. The freeze holds the PC and the fetch/decode register, and it sets the next nop bit of the execute stage so that a bubble enters there. Once the stall is over, the loaded value reaches the dependent instruction from the writeback stage.

Branch operands are never checked, because a branch is guaranteed to have no dependency on either of the two instructions ahead of it. Register data, the ALU and the memories live outside the unit.

Top module: `hz_unit`

## Requirements
- R1: Operand select encoding is 2'b00 = register-file value, 2'b01 = result held in the memory stage, 2'b10 = value in the writeback stage. A source is given 2'b01 when the memory stage has write-enable set, nop clear, its load flag clear, and a destination equal to that source.
- R2: If R1 does not apply, a source is given 2'b10 when the writeback stage has write-enable set, nop clear, and a destination equal to that source. Otherwise the select is 2'b00.
- R3: When both the memory stage and the writeback stage qualify for the same source, the memory stage (2'b01) wins.
- R4: A source address of 0 is never forwarded; its select is always 2'b00.
- R5: A load sitting in the memory stage is never a forwarding source; its data is not yet available there.
- R6: `fwd_a` serves the first source of execute and `fwd_b` the second. `fwd_store` equals `fwd_b` when execute holds a valid store and is 2'b00 otherwise. All three selects are 2'b00 when execute's nop bit is set.
- R7: `freeze_front` is 1 exactly when all of the following hold:
  - execute holds a valid load (load flag and write-enable set, nop clear) with a nonzero destination;
  - decode is valid, not a branch, and its first source equals that destination, or it uses its second source and that source equals the destination.
- R8: No freeze is raised for a branch in decode, a nop in decode or execute, a zero destination, or a second-source match when decode does not use its second source.
- R9: `ex_nop_d`, the next nop bit for execute, is 1 when decode is a nop or when `freeze_front` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | first source address in decode |
| id_rs2 | input | AW | second source address in decode |
| id_uses_rs2 | input | 1 | decode instruction reads its second source |
| id_is_branch | input | 1 | decode holds a branch |
| id_nop | input | 1 | decode stage invalid |
| ex_rs1 | input | AW | first source address in execute |
| ex_rs2 | input | AW | second source address in execute |
| ex_rd | input | AW | destination address in execute |
| ex_wen | input | 1 | execute instruction writes a register |
| ex_rdmem | input | 1 | execute holds a load |
| ex_wrmem | input | 1 | execute holds a store |
| ex_nop | input | 1 | execute stage invalid |
| mem_rd | input | AW | destination address in memory stage |
| mem_wen | input | 1 | memory-stage instruction writes a register |
| mem_rdmem | input | 1 | memory stage holds a load |
| mem_nop | input | 1 | memory stage invalid |
| wb_rd | input | AW | destination address in writeback |
| wb_wen | input | 1 | writeback instruction writes a register |
| wb_nop | input | 1 | writeback stage invalid |
| fwd_a | output | 2 | select for execute first operand |
| fwd_b | output | 2 | select for execute second operand |
| fwd_store | output | 2 | select for store data |
| freeze_front | output | 1 | hold PC and fetch/decode register |
| ex_nop_d | output | 1 | next nop bit for execute |

## Verification
The bench sweeps every combination of small register addresses together with each stage's valid, write and load flags. This exposes several classes of error:
- A design that forgets the x0 exclusion forwards garbage into operands that name register 0.
- A design with the priority reversed hands an instruction the older writeback value when a newer result sits in the memory stage.
- A design that forwards from a load in the memory stage delivers an address instead of data.
- On the stall side, the sweep confirms that branches, nops and unused second sources never freeze the front end. A design that got any of these wrong would lose cycles, or deadlock when it sees a branch after a load.
- The sweep also confirms that every freeze is paired with a bubble into execute. Without that bubble, the dependent instruction would run twice.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_e;

    typedef struct packed {
        fwd_e  op_a;
        fwd_e  op_b;
        fwd_e  st;
        logic  freeze;
        logic  bubble;
    } hz_out_t;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic          active,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_ok,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_ok,
    output fwd_e          sel
);
    logic nonzero;
    logic hit_mem;
    logic hit_wb;

    always_comb begin
        nonzero = (src != '0);
        hit_mem = active && nonzero && mem_ok && (mem_rd == src);
        hit_wb  = active && nonzero && wb_ok  && (wb_rd  == src);
        if (hit_mem)      sel = FWD_MEM;
        else if (hit_wb)  sel = FWD_WB;
        else              sel = FWD_RF;
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_uses_rs2,
    input  logic          id_is_branch,
    input  logic          id_nop,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_rdmem,
    input  logic          ex_nop,
    output logic          stall
);
    logic ld_live;
    logic id_live;
    logic dep1;
    logic dep2;

    always_comb begin
        ld_live = ex_rdmem && ex_wen && !ex_nop && (ex_rd != '0);
        id_live = !id_nop && !id_is_branch;
        dep1    = (id_rs1 == ex_rd);
        dep2    = id_uses_rs2 && (id_rs2 == ex_rd);
        stall   = ld_live && id_live && (dep1 || dep2);
    end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_uses_rs2,
    input  logic          id_is_branch,
    input  logic          id_nop,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_rdmem,
    input  logic          ex_wrmem,
    input  logic          ex_nop,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic          mem_rdmem,
    input  logic          mem_nop,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    input  logic          wb_nop,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic [1:0]    fwd_store,
    output logic          freeze_front,
    output logic          ex_nop_d
);
    localparam int NSRC = 2;

    logic [AW-1:0] src_q   [NSRC];
    fwd_e          sel_d   [NSRC];
    logic          mem_ok;
    logic          wb_ok;
    logic          stall_d;
    hz_out_t       out_d;

    // A load in the memory stage has no data yet, so it never qualifies (R5).
    assign mem_ok   = mem_wen && !mem_nop && !mem_rdmem;
    assign wb_ok    = wb_wen && !wb_nop;
    assign src_q[0] = ex_rs1;
    assign src_q[1] = ex_rs2;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hz_fwd_pick #(.AW(AW)) u_pick (
            .src    (src_q[g]),
            .active (!ex_nop),
            .mem_rd (mem_rd),
            .mem_ok (mem_ok),
            .wb_rd  (wb_rd),
            .wb_ok  (wb_ok),
            .sel    (sel_d[g])
        );
    end

    hz_load_use #(.AW(AW)) u_lu (
        .id_rs1       (id_rs1),
        .id_rs2       (id_rs2),
        .id_uses_rs2  (id_uses_rs2),
        .id_is_branch (id_is_branch),
        .id_nop       (id_nop),
        .ex_rd        (ex_rd),
        .ex_wen       (ex_wen),
        .ex_rdmem     (ex_rdmem),
        .ex_nop       (ex_nop),
        .stall        (stall_d)
    );

    always_comb begin
        out_d.op_a   = sel_d[0];
        out_d.op_b   = sel_d[1];
        out_d.st     = (ex_wrmem && !ex_nop) ? sel_d[1] : FWD_RF;
        out_d.freeze = stall_d;
        out_d.bubble = id_nop || stall_d;
    end

    assign fwd_a        = out_d.op_a;
    assign fwd_b        = out_d.op_b;
    assign fwd_store    = out_d.st;
    assign freeze_front = out_d.freeze;
    assign ex_nop_d     = out_d.bubble;
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] ex_rs1,
    input logic          ex_wrmem,
    input logic          ex_nop,
    input logic [AW-1:0] mem_rd,
    input logic          mem_wen,
    input logic          mem_rdmem,
    input logic          mem_nop,
    input logic          id_is_branch,
    input logic          id_nop,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_store,
    input logic          freeze_front,
    input logic          ex_nop_d
);
    always_comb begin
        p_mem_first_r3: assert (!(fwd_a == 2'b10 && mem_wen && !mem_nop && !mem_rdmem
                                  && mem_rd == ex_rs1 && !ex_nop))
            else $error("R3 writeback chosen over memory stage");
        p_no_x0_r4: assert (!(ex_rs1 == '0 && fwd_a != 2'b00))
            else $error("R4 x0 forwarded");
        p_no_load_src_r5: assert (!(mem_rdmem && fwd_a == 2'b01))
            else $error("R5 forwarded from load in memory stage");
        p_store_idle_r6: assert (!((!ex_wrmem || ex_nop) && fwd_store != 2'b00))
            else $error("R6 store select active without store");
        p_branch_free_r8: assert (!((id_is_branch || id_nop) && freeze_front))
            else $error("R8 freeze on branch or nop");
        p_freeze_bubble_r9: assert (!(freeze_front && !ex_nop_d))
            else $error("R9 freeze without bubble");
    end
endmodule

bind hz_unit hz_unit_chk #(.AW(AW)) u_chk (
    .ex_rs1       (ex_rs1),
    .ex_wrmem     (ex_wrmem),
    .ex_nop       (ex_nop),
    .mem_rd       (mem_rd),
    .mem_wen      (mem_wen),
    .mem_rdmem    (mem_rdmem),
    .mem_nop      (mem_nop),
    .id_is_branch (id_is_branch),
    .id_nop       (id_nop),
    .fwd_a        (fwd_a),
    .fwd_store    (fwd_store),
    .freeze_front (freeze_front),
    .ex_nop_d     (ex_nop_d)
);

// File: tb/sim_hz_unit.sv
module sim_hz_unit;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_uses_rs2, id_is_branch, id_nop;
    logic ex_wen, ex_rdmem, ex_wrmem, ex_nop;
    logic mem_wen, mem_rdmem, mem_nop, wb_wen, wb_nop;
    logic [1:0] fwd_a, fwd_b, fwd_store;
    logic freeze_front, ex_nop_d;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    hz_unit #(.AW(AW)) u0 (.*);

    task automatic chk2(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
        // R1/R2/R3/R4/R5 computed from the requirement text
        if (ex_nop || s == 0) return 2'b00;
        if (mem_wen && !mem_nop && !mem_rdmem && mem_rd == s) return 2'b01;
        if (wb_wen && !wb_nop && wb_rd == s) return 2'b10;
        return 2'b00;
    endfunction

    initial begin : watchdog
        #500000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [1:0] e;
        logic ld, st;
        id_rs1 = 0; id_rs2 = 0; id_uses_rs2 = 0; id_is_branch = 0; id_nop = 1;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_wen = 0; ex_rdmem = 0; ex_wrmem = 0; ex_nop = 1;
        mem_rd = 0; mem_wen = 0; mem_rdmem = 0; mem_nop = 1;
        wb_rd = 0; wb_wen = 0; wb_nop = 1;
        @(negedge clk);
        // reset-like idle: all stages nop
        chk2("R6 idle fwd_a", fwd_a, 2'b00);
        chk2("R7 idle freeze", {1'b0, freeze_front}, 2'b00);
        chk2("R9 idle bubble", {1'b0, ex_nop_d}, 2'b01);

        // Forwarding sweep (R1..R6)
        for (int s = 0; s < 4; s++)
        for (int mr = 0; mr < 4; mr++)
        for (int wr = 0; wr < 4; wr++)
        for (int f = 0; f < 64; f++) begin
            ex_rs1 = AW'(s); ex_rs2 = AW'((s + 1) % 4);
            mem_rd = AW'(mr); wb_rd = AW'(wr);
            mem_wen = f[0]; mem_nop = f[1]; mem_rdmem = f[2];
            wb_wen = f[3]; wb_nop = f[4]; ex_nop = f[5];
            ex_wrmem = f[0] ^ f[3];
            #1;
            e = exp_sel(ex_rs1);
            chk2("R1/R2/R3/R4/R5 fwd_a", fwd_a, e);
            e = exp_sel(ex_rs2);
            chk2("R6 fwd_b", fwd_b, e);
            chk2("R6 fwd_store", fwd_store, (ex_wrmem && !ex_nop) ? e : 2'b00);
            @(negedge clk);
        end

        // Stall sweep (R7..R9)
        mem_nop = 1; wb_nop = 1; ex_wrmem = 0;
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
        for (int d = 0; d < 4; d++)
        for (int f = 0; f < 64; f++) begin
            id_rs1 = AW'(a); id_rs2 = AW'(b); ex_rd = AW'(d);
            ex_rdmem = f[0]; ex_wen = f[1]; ex_nop = f[2];
            id_nop = f[3]; id_is_branch = f[4]; id_uses_rs2 = f[5];
            #1;
            ld = ex_rdmem && ex_wen && !ex_nop && d != 0;
            st = ld && !id_nop && !id_is_branch
                 && (a == d || (id_uses_rs2 && b == d));
            chk2("R7/R8 freeze_front", {1'b0, freeze_front}, {1'b0, st});
            chk2("R9 ex_nop_d", {1'b0, ex_nop_d}, {1'b0, id_nop | st});
            @(negedge clk);
        end

        // Directed: load-use then forward from writeback after stall (R7, R2)
        id_nop = 0; id_is_branch = 0; id_uses_rs2 = 0; id_rs1 = 3;
        ex_rd = 3; ex_wen = 1; ex_rdmem = 1; ex_nop = 0;
        #1;
        chk2("R7 load-use freeze", {1'b0, freeze_front}, 2'b01);
        @(negedge clk);
        ex_rs1 = 3; ex_nop = 0; mem_nop = 1;
        wb_rd = 3; wb_wen = 1; wb_nop = 0;
        #1;
        chk2("R2 load value from writeback", fwd_a, 2'b10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule